// File: doc/BRIEF.md
# TDM Serial Stream Channel Engine

This block sits between a 2048 kbit/s time-division serial stream and three byte-wide channel memories of 32 bytes each. Incoming serial bits are gathered into bytes and stored in a receive memory, one byte per channel. Two transmit memories are read one channel ahead and shifted out on two serial outputs. A synchronous host port reads and writes all three memories. Frame, channel and bit timing come from a counter clocked by the 4.096 MHz bit-rate clock and aligned by an active-low frame pulse.

There are two channel mappings. In the 32-slot mapping, memory byte k belongs to serial slot k. In the 24-slot mapping, every fourth slot starting at slot 0 sends all-ones and is not stored. The other 24 slots use memory bytes 0 to 23 in order. Output 0 can carry the input directly. The receive memory can be fed from transmit memory 0 instead of the input. Output 1 can carry transmit memory 1, the input delayed by one frame through transmit memory 1, or either of these XORed with the live input.

Top module: `tdm_stream_engine`

## Requirements
- R1: When `fp_ni` is sampled low at a clock edge, after having been sampled high at the edge before, the following cycle is cycle 0 of a frame. Cycle 0 is channel 0, bit 7.
- R2: Each bit lasts 2 clock cycles and each channel lasts 16. Bits are sent most significant first, so frame cycle k carries bit 7-((k/2) mod 8) of channel k/16.
- R3: When `ch24_i`=0, serial channel c uses memory byte c for both transmit and receive.
- R4: When `ch24_i`=1, channels with c mod 4 = 0 send 8'hFF from every memory-sourced output and store nothing. Every other channel c uses memory byte c - c/4 - 1.
- R5: The input is sampled in the second cycle of each bit. A channel's byte is written to the receive memory only at the end of the channel's last cycle, and it can be read from the host port from the next cycle on.
- R6: `loop_sel_i`: bit 0 set sends `si_i` directly on `so0_o`, otherwise `so0_o` sends transmit memory 0. Bit 1 set makes the receive memory take the transmit memory 0 stream and ignore `si_i`.
- R7: `out1_sel_i`: bit 0 set writes each received input byte (taken from `si_i` before any loopback) into transmit memory 1 at its channel's index, at the channel end. This delays the input by one frame. Bit 1 set sends `si_i` XOR the transmit memory 1 bit on `so1_o`, otherwise the transmit memory 1 bit is sent.
- R8: Host address {sel[1:0], idx[4:0]}: sel 0 = receive memory, 1 = transmit 0, 2 = transmit 1, 3 = none. Read data returns 0 for sel 3. Read data appears on `host_rdata_o` one cycle after the access. Host writes to sel 0 or 3 change nothing.
- R9: Without a frame pulse, the cycle counter wraps from frame cycle 511 to 0 and frames carry on unchanged.
- R10: In reset, both serial outputs and `host_rdata_o` are 0, and all memories hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4.096 MHz bit-rate clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| fp_ni | input | 1 | active-low frame alignment pulse |
| si_i | input | 1 | serial input stream |
| so0_o | output | 1 | serial output 0 |
| so1_o | output | 1 | serial output 1 |
| ch24_i | input | 1 | 1 selects the 24-slot mapping |
| loop_sel_i | input | 2 | loopback select |
| out1_sel_i | input | 2 | output 1 function select |
| host_cs_i | input | 1 | host access strobe |
| host_we_i | input | 1 | host write (1) or read (0) |
| host_addr_i | input | 7 | memory select and byte index |
| host_wdata_i | input | 8 | host write data |
| host_rdata_o | output | 8 | host read data, one cycle latency |

## Verification
A cycle counter that is out of step shows on both outputs within one bit cell. Each output bit is compared with the bench's own frame position in every cycle, so a slip of even one cycle fails at once. A wrong slot-to-index mapping, or a write at the wrong moment, shows up when the host reads the receive byte one channel later. In the delay mode it also shows up a frame later on output 1. The tests sweep full frames under every loopback and output-1 setting, in both mappings, across a free wrap and across a re-alignment in mid-frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int CH_NUM = 32;
  localparam int BYTE_W = 8;
  localparam int CH_W   = $clog2(CH_NUM);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int CNT_W  = CH_W + BIT_W + 1;
  localparam int MEM_N  = 3;
  localparam int HA_W   = CH_W + 2;

  typedef enum logic [1:0] {
    MSEL_RX  = 2'd0,
    MSEL_TX0 = 2'd1,
    MSEL_TX1 = 2'd2,
    MSEL_NONE = 2'd3
  } mem_sel_e;

  // dense index for a slot; in 24-slot mapping every fourth slot is skipped
  function automatic logic [CH_W-1:0] slot_index(input logic [CH_W-1:0] ch,
                                                 input logic ch24);
    logic [CH_W-1:0] skipped;
    skipped = ch >> 2;
    return ch24 ? ch - skipped - CH_W'(1) : ch;
  endfunction

  function automatic logic slot_idle(input logic [CH_W-1:0] ch, input logic ch24);
    return ch24 && (ch[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/tdm_timing.sv
module tdm_timing
  import tdm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic fp_q;

  assign cnt_nxt_o = (fp_q && !fp_ni) ? '0 : cnt_o + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q  <= 1'b1;
      cnt_o <= '0;
    end else begin
      fp_q  <= fp_ni;
      cnt_o <= cnt_nxt_o;
    end
  end
endmodule

// File: rtl/tdm_chan_mem.sv
module tdm_chan_mem #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [W-1:0]  a_wdata_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [W-1:0]  b_wdata_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [W-1:0]  ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [W-1:0]  rb_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];

  // port b (serial side) wins a same-address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (a_we_i && !(b_we_i && (a_addr_i == b_addr_i))) mem_q[a_addr_i] <= a_wdata_i;
      if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
    end
  end
endmodule

// File: rtl/tdm_stream_engine.sv
module tdm_stream_engine
  import tdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_ni,
  input  logic              si_i,
  output logic              so0_o,
  output logic              so1_o,
  input  logic              ch24_i,
  input  logic [1:0]        loop_sel_i,
  input  logic [1:0]        out1_sel_i,
  input  logic              host_cs_i,
  input  logic              host_we_i,
  input  logic [HA_W-1:0]   host_addr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o
);
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [CH_W-1:0]   cur_ch, nxt_ch;
  logic [BIT_W-1:0]  bit_pos;
  logic              load_tx, chan_end, sample_en;

  tdm_timing u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fp_ni    (fp_ni),
    .cnt_o    (cnt),
    .cnt_nxt_o(cnt_nxt)
  );

  assign cur_ch    = cnt[CNT_W-1 -: CH_W];
  assign nxt_ch    = cnt_nxt[CNT_W-1 -: CH_W];
  assign bit_pos   = ~cnt[BIT_W:1];
  assign sample_en = cnt[0];
  assign load_tx   = (cnt_nxt[BIT_W:0] == '0);
  assign chan_end  = (cnt[BIT_W:0] == '1);

  // host side
  mem_sel_e           h_sel;
  logic [CH_W-1:0]    h_idx;
  logic               h_wr;
  logic [MEM_N-1:0]   host_we;
  logic [BYTE_W-1:0]  host_rd [MEM_N];

  assign h_sel = mem_sel_e'(host_addr_i[HA_W-1 -: 2]);
  assign h_idx = host_addr_i[CH_W-1:0];
  assign h_wr  = host_cs_i && host_we_i;
  assign host_we = {h_wr && (h_sel == MSEL_TX1), h_wr && (h_sel == MSEL_TX0), 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_rdata_o <= '0;
    else if (host_cs_i && !host_we_i) begin
      unique case (h_sel)
        MSEL_RX:  host_rdata_o <= host_rd[0];
        MSEL_TX0: host_rdata_o <= host_rd[1];
        MSEL_TX1: host_rdata_o <= host_rd[2];
        default:  host_rdata_o <= '0;
      endcase
    end
  end

  // serial side
  logic [BYTE_W-1:0] tx0_q, tx1_q, rx_sh_q, raw_sh_q;
  logic [BYTE_W-1:0] rx_byte, raw_byte;
  logic              tx0_bit, tx1_bit, rx_bit, cur_idle;
  logic [CH_W-1:0]   ser_rd_idx, ser_wr_idx;
  logic [MEM_N-1:0]  ser_we;
  logic [BYTE_W-1:0] ser_wdata [MEM_N];
  logic [BYTE_W-1:0] ser_rd    [MEM_N];
  logic              rx_ser_unused;

  assign ser_rd_idx = slot_index(nxt_ch, ch24_i);
  assign ser_wr_idx = slot_index(cur_ch, ch24_i);
  assign cur_idle   = slot_idle(cur_ch, ch24_i);

  assign tx0_bit  = tx0_q[bit_pos];
  assign tx1_bit  = tx1_q[bit_pos];
  assign rx_bit   = loop_sel_i[1] ? tx0_bit : si_i;
  assign rx_byte  = {rx_sh_q[BYTE_W-2:0], rx_bit};
  assign raw_byte = {raw_sh_q[BYTE_W-2:0], si_i};

  assign ser_we       = {chan_end && !cur_idle && out1_sel_i[0], 1'b0, chan_end && !cur_idle};
  assign ser_wdata[0] = rx_byte;
  assign ser_wdata[1] = '0;
  assign ser_wdata[2] = raw_byte;
  assign rx_ser_unused = ^ser_rd[0];

  for (genvar gi = 0; gi < MEM_N; gi++) begin : g_mem
    tdm_chan_mem #(.DEPTH(CH_NUM), .W(BYTE_W)) u_mem (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_we_i   (host_we[gi]),
      .a_addr_i (h_idx),
      .a_wdata_i(host_wdata_i),
      .b_we_i   (ser_we[gi]),
      .b_addr_i (ser_wr_idx),
      .b_wdata_i(ser_wdata[gi]),
      .ra_addr_i(h_idx),
      .ra_data_o(host_rd[gi]),
      .rb_addr_i(ser_rd_idx),
      .rb_data_o(ser_rd[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx0_q    <= '0;
      tx1_q    <= '0;
      rx_sh_q  <= '0;
      raw_sh_q <= '0;
    end else begin
      if (load_tx) begin
        // fetch next channel one edge ahead of its first bit
        tx0_q <= slot_idle(nxt_ch, ch24_i) ? '1 : ser_rd[1];
        tx1_q <= slot_idle(nxt_ch, ch24_i) ? '1 : ser_rd[2];
      end
      if (sample_en) begin
        rx_sh_q  <= rx_byte;
        raw_sh_q <= raw_byte;
      end
    end
  end

  assign so0_o = loop_sel_i[0] ? si_i : tx0_bit;
  assign so1_o = out1_sel_i[1] ? (si_i ^ tx1_bit) : tx1_bit;
endmodule

// File: rtl/tdm_stream_engine_chk.sv
module tdm_stream_engine_chk
  import tdm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fp_ni,
  input logic             so0_o,
  input logic             so1_o,
  input logic             ch24_i,
  input logic [1:0]       loop_sel_i,
  input logic [1:0]       out1_sel_i,
  input logic [CNT_W-1:0] cnt
);
  logic fp_d, rst_seen;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_d     <= 1'b1;
      rst_seen <= 1'b0;
    end else begin
      fp_d     <= fp_ni;
      rst_seen <= 1'b1;
    end
  end

  assign fall = fp_d && !fp_ni;

  a_r1_frame_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> (cnt == '0));

  a_r9_free_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall && (cnt == '1)) |=> (cnt == '0));

  a_r2_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall && (cnt != '1)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R4: idle slot of 24-slot mapping starts with all-ones on memory-sourced outputs
  a_r4_idle_so0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_seen && $past(rst_seen) && (cnt[BIT_W:0] == '0) && (cnt[BIT_W+2:BIT_W+1] == 2'b00)
     && $past(ch24_i) && !loop_sel_i[0]) |-> so0_o);

  a_r4_idle_so1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_seen && $past(rst_seen) && (cnt[BIT_W:0] == '0) && (cnt[BIT_W+2:BIT_W+1] == 2'b00)
     && $past(ch24_i) && (out1_sel_i == 2'b00)) |-> so1_o);
endmodule

bind tdm_stream_engine tdm_stream_engine_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fp_ni     (fp_ni),
  .so0_o     (so0_o),
  .so1_o     (so1_o),
  .ch24_i    (ch24_i),
  .loop_sel_i(loop_sel_i),
  .out1_sel_i(out1_sel_i),
  .cnt       (cnt)
);

// File: tb/tdm_stream_engine_tb.sv
`timescale 1ns/1ps
module tdm_stream_engine_tb_top;
  localparam int CLK_PERIOD = 244;
  localparam int FRAME_CYC  = 512;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fp_ni = 1'b1;
  logic       si_i = 1'b0;
  logic       so0_o, so1_o;
  logic       ch24_i = 1'b0;
  logic [1:0] loop_sel_i = 2'b00;
  logic [1:0] out1_sel_i = 2'b00;
  logic       host_cs_i = 1'b0;
  logic       host_we_i = 1'b0;
  logic [6:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  int gf = 0;

  logic [7:0] tx0m [32];
  logic [7:0] t1m  [32];
  logic [7:0] rxm  [32];

  tdm_stream_engine dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] gen(input int f, input int c);
    return 8'(c * 37 + f * 101 + 5);
  endfunction

  function automatic int idx_of(input int c, input bit c24);
    return c24 ? c - c / 4 - 1 : c;
  endfunction

  task automatic host_write(input logic [1:0] sel, input int idx, input logic [7:0] d);
    @(negedge clk_i);
    host_cs_i = 1'b1; host_we_i = 1'b1; host_addr_i = {sel, 5'(idx)}; host_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    host_cs_i = 1'b0; host_we_i = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, input int idx, output logic [7:0] d);
    @(negedge clk_i);
    host_cs_i = 1'b1; host_we_i = 1'b0; host_addr_i = {sel, 5'(idx)};
    @(posedge clk_i);
    @(negedge clk_i);
    host_cs_i = 1'b0;
    #1 d = host_rdata_o;
  endtask

  // full-frame sweep; pulse=0 continues on the free-running counter
  task automatic run(input int ncyc, input bit pulse, input bit c24,
                     input logic [1:0] lb, input logic [1:0] s1);
    bit prev_ok;
    logic [7:0] rd_exp;
    prev_ok = !pulse;
    rd_exp = '0;
    if (pulse) begin
      @(negedge clk_i);
      fp_ni = 1'b0; ch24_i = c24; loop_sel_i = lb; out1_sel_i = s1;
      @(posedge clk_i);
    end
    for (int n = 0; n < ncyc; n++) begin
      int k, ch, b, ix, pc;
      bit idle, sib;
      logic [7:0] gin, t0b, t1b;
      k = n % FRAME_CYC;
      ch = k / 16;
      b = 7 - ((k / 2) % 8);
      idle = c24 && (ch % 4 == 0);
      ix = idx_of(ch, c24);
      gin = gen(gf, ch);
      sib = gin[b];
      t0b = idle ? 8'hFF : tx0m[ix];
      t1b = idle ? 8'hFF : t1m[ix];
      @(negedge clk_i);
      fp_ni = 1'b1;
      si_i = sib;
      if (k % 16 == 1) host_cs_i = 1'b0;
      #1;
      // R2 R3 R4 R6: output 0 bit for this frame cycle
      chk(so0_o === (lb[0] ? sib : t0b[b]), "R2/R3/R4/R6 so0", so0_o, lb[0] ? sib : t0b[b]);
      // R7: output 1 bit
      chk(so1_o === (s1[1] ? (sib ^ t1b[b]) : t1b[b]), "R7/R4 so1", so1_o,
          s1[1] ? (sib ^ t1b[b]) : t1b[b]);
      if (k % 16 == 1 && prev_ok && !(c24 && (((ch + 31) % 32) % 4 == 0)))
        // R5: previous channel's byte readable in receive memory
        chk(host_rdata_o === rd_exp, "R5/R6 rx byte", host_rdata_o, rd_exp);
      if (k % 16 == 0) begin
        pc = (ch + 31) % 32;
        if (!(c24 && (pc % 4 == 0))) begin
          host_cs_i = 1'b1; host_we_i = 1'b0;
          host_addr_i = {2'b00, 5'(idx_of(pc, c24))};
          rd_exp = rxm[idx_of(pc, c24)];
        end
      end
      @(posedge clk_i);
      if (k % 16 == 15) begin
        prev_ok = 1'b1;
        if (!idle) begin
          rxm[ix] = lb[1] ? t0b : gin;
          if (s1[0]) t1m[ix] = gin;
        end
      end
      if (k == FRAME_CYC - 1) gf++;
    end
  endtask

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 32; i++) begin
      tx0m[i] = '0; t1m[i] = '0; rxm[i] = '0;
    end
    #(CLK_PERIOD * 3 + 10);
    // R10: reset state
    chk(so0_o === 1'b0, "R10 so0 reset", so0_o, 0);
    chk(so1_o === 1'b0, "R10 so1 reset", so1_o, 0);
    chk(host_rdata_o === 8'h00, "R10 rdata reset", host_rdata_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i);

    // R8: receive memory not writable from host; sel 3 reads 0
    host_write(2'd0, 3, 8'h5A);
    host_read(2'd0, 3, d);
    chk(d === 8'h00, "R8 rx write ignored", d, 0);
    host_write(2'd3, 3, 8'h77);
    host_read(2'd3, 3, d);
    chk(d === 8'h00, "R8 sel3 reads zero", d, 0);

    for (int i = 0; i < 32; i++) begin
      tx0m[i] = 8'(i * 7 + 3) ^ 8'h3C;
      t1m[i]  = 8'(i) ^ 8'hA5;
      host_write(2'd1, i, tx0m[i]);
      host_write(2'd2, i, t1m[i]);
    end
    host_read(2'd1, 0, d);
    chk(d === tx0m[0], "R8 tx0 readback 0", d, tx0m[0]);
    host_read(2'd1, 31, d);
    chk(d === tx0m[31], "R8 tx0 readback 31", d, tx0m[31]);
    host_read(2'd2, 17, d);
    chk(d === t1m[17], "R8 tx1 readback 17", d, t1m[17]);

    // R1 R3: aligned 32-slot frames, plain outputs
    run(2 * FRAME_CYC, 1'b1, 1'b0, 2'b00, 2'b00);
    // R9: no pulse, counter wraps and frames continue
    run(FRAME_CYC, 1'b0, 1'b0, 2'b00, 2'b00);
    // R4 R7: 24-slot mapping with one-frame delay on output 1
    run(2 * FRAME_CYC, 1'b1, 1'b1, 2'b00, 2'b01);
    // R6 R7: input looped to output 0, XOR on output 1; stopped mid-frame
    run(200, 1'b1, 1'b0, 2'b01, 2'b10);
    // R1: re-alignment mid-frame; R6 transmit loop into receive, R7 delayed XOR
    run(2 * FRAME_CYC, 1'b1, 1'b0, 2'b10, 2'b11);
    // R4 R6: both loops in 24-slot mapping
    run(FRAME_CYC, 1'b1, 1'b1, 2'b11, 2'b00);

    // R7: transmit memory 1 now holds the delayed input of the last delay frame
    host_read(2'd2, 9, d);
    chk(d === t1m[9], "R7 tx1 holds delayed input", d, t1m[9]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule